// File: doc/BRIEF.md
# Quad-Wire DDR Serial Flash Transaction Controller

This block is the host side of a serial NOR flash link. It takes one request at a time: an 8-bit command, a 24-bit address, a byte count, a read/write flag and a latency setting. It then runs the whole transaction on the flash pins. The command goes out serially on one data line at single data rate. The address and any write data go out on all four data lines, one nibble per serial-clock edge. For a read, the bus is released after the address, a configured number of dummy clock periods is counted, and nibbles are then sampled on both clock edges and packed into bytes.

The core clock runs at twice the serial-clock edge rate. The serial clock changes at most every second core cycle, and host-driven data changes in the core cycle between two clock edges. This leaves one core cycle of setup and one of hold around every edge the flash samples. Chip select stays low from the command to the last data edge. The serial clock is held low whenever chip select is high.

Write bytes are pulled from an upstream show-ahead source with a one-cycle pop strobe. Read bytes leave with a one-cycle valid strobe.

Top module: `qspi_ddr_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, dq_oe_o is 0000, busy_o is 0, rd_valid_o is 0 and wr_pop_o is 0.
- R2: A request seen while idle raises busy_o in the next cycle, and cs_n_o falls one cycle after that. A request raised while busy_o is 1 has no effect on any output.
- R3: The 8 command bits go out most significant bit first on dq_o[0], with dq_oe_o = 0001. Each bit is held for one full serial-clock period (four core cycles) and is placed one core cycle before its rising edge.
- R4: While chip select is low, sck_o toggles every second core cycle, starting low. Any change of dq_o or dq_oe_o happens in the core cycle before a toggle.
- R5: After the command, the 24-bit address goes out as 6 nibbles on dq_o[3:0], most significant nibble first, one nibble per serial-clock edge, with dq_oe_o = 1111.
- R6: For a read, dq_oe_o goes to 0000 in the core cycle after the last address edge, and stays 0000 until the end. The controller then counts 2 x lat_i serial-clock edges (lat_i full clock periods, 0 to 15) before the first data edge. cs_n_o stays low throughout.
- R7: For a read, dq_i is sampled in the core cycle after each data edge. The first nibble of each byte is the upper nibble. rd_data_o is valid while rd_valid_o is 1, and rd_valid_o is high for one cycle, starting one core cycle after the edge that completes the byte.
- R8: For a write, wr_pop_o pulses in the cycle the upper nibble of a byte is placed on dq_o. wr_data_i is sampled in that cycle and its lower nibble follows on the next edge. Exactly len_i pops occur.
- R9: cs_n_o rises one core cycle after the final serial-clock edge. sck_o is low at that point and no further edges follow. A byte count of 0 ends the transaction after the address (or after the latency on a read).
- R10: sck_o is 0 in every cycle where cs_n_o is 1.
- R11: busy_o falls in the same cycle cs_n_o rises. A request in the next cycle is accepted, which gives at least two core cycles of chip select high between transactions.
- R12: A read with lat_i = 0 samples its first data nibble after the first edge that follows the last address edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the serial-clock edge rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken only while idle |
| write_i | input | 1 | 1 = write transaction, 0 = read |
| opcode_i | input | 8 | Command byte |
| addr_i | input | 24 | Flash byte address |
| len_i | input | LEN_W | Data byte count, 0 allowed |
| lat_i | input | 4 | Read latency in serial-clock periods |
| busy_o | output | 1 | Transaction in progress |
| wr_data_i | input | 8 | Next write byte (show-ahead) |
| wr_pop_o | output | 1 | Write byte consumed this cycle |
| rd_data_o | output | 8 | Assembled read byte |
| rd_valid_o | output | 1 | rd_data_o valid strobe |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Flash serial clock |
| dq_o | output | 4 | Data lines out |
| dq_oe_o | output | 4 | Per-line output enable |
| dq_i | input | 4 | Data lines in |

## Verification
The hardest case to reach is the read turnaround. Here the address has just ended, the data lines are released, the latency count runs with no chip-select edge to mark it, and the first captured nibble has to line up with the flash model's first data edge. The bench's flash model counts serial-clock edges itself from the moment chip select falls, and only drives read nibbles after edge 22 + 2 x latency. Any off-by-one error in the latency or capture logic therefore shows up as wrong bytes. The stimulus covers latency 0, 1, 2, 8 and 15, and zero-length reads and writes. Transactions are issued back to back to probe the minimum chip-select gap, and extra requests are raised mid-transaction to show they have no effect.

// File: rtl/qspi_ddr_pkg.sv
package qspi_ddr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_CMD, ST_ADDR, ST_LAT, ST_WDATA, ST_RDATA, ST_END
  } state_e;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/qspi_ddr_seq.sv
module qspi_ddr_seq
  import qspi_ddr_pkg::*;
#(
  parameter int OP_W      = 8,
  parameter int ADDR_NIBS = 6,
  parameter int LEN_W     = 8,
  parameter int LAT_W     = 4,
  parameter int CNT_W     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             write_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [LEN_W-1:0] len_i,
  output state_e           state_o,
  output logic             cnt_lsb_o,
  output logic             start_o,
  output logic             launch_o,
  output logic             sck_tgl_o,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             busy_o
);
  state_e           state_q, nxt;
  logic             ph_q, cs_n_q, sck_q, busy_q, write_q, active;
  logic [CNT_W-1:0] cnt_q, last;
  logic [LAT_W-1:0] lat_q;
  logic [LEN_W-1:0] len_q;
  logic             len_zero, lat_zero;

  assign active   = state_q inside {ST_CMD, ST_ADDR, ST_LAT, ST_WDATA, ST_RDATA};
  assign len_zero = (len_q == '0);
  assign lat_zero = (lat_q == '0);

  // edge budget of the current phase and its successor
  always_comb begin
    last = '0;
    nxt  = ST_END;
    case (state_q)
      ST_CMD: begin
        last = CNT_W'(2*OP_W-1);
        nxt  = ST_ADDR;
      end
      ST_ADDR: begin
        last = CNT_W'(ADDR_NIBS-1);
        if (write_q)        nxt = len_zero ? ST_END : ST_WDATA;
        else if (!lat_zero) nxt = ST_LAT;
        else                nxt = len_zero ? ST_END : ST_RDATA;
      end
      ST_LAT: begin
        last = CNT_W'({lat_q, 1'b0}) - CNT_W'(1);
        nxt  = len_zero ? ST_END : ST_RDATA;
      end
      ST_WDATA, ST_RDATA: begin
        last = CNT_W'({len_q, 1'b0}) - CNT_W'(1);
        nxt  = ST_END;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      cnt_q   <= '0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      busy_q  <= 1'b0;
      write_q <= 1'b0;
      lat_q   <= '0;
      len_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_START;
          busy_q  <= 1'b1;
          write_q <= write_i;
          lat_q   <= lat_i;
          len_q   <= len_i;
        end
        ST_START: begin
          cs_n_q  <= 1'b0;
          state_q <= ST_CMD;
          ph_q    <= 1'b0;
          cnt_q   <= '0;
        end
        ST_END: begin
          cs_n_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            sck_q <= ~sck_q;
            if (cnt_q == last) begin
              cnt_q   <= '0;
              state_q <= nxt;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign state_o   = state_q;
  assign cnt_lsb_o = cnt_q[0];
  assign start_o   = (state_q == ST_IDLE) && req_i;
  assign launch_o  = active && !ph_q;
  assign sck_tgl_o = active && ph_q;
  assign cs_n_o    = cs_n_q;
  assign sck_o     = sck_q;
  assign busy_o    = busy_q;

  a_r2_cs_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |=> $fell(cs_n_q));
  a_r4_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sck_q) |=> $stable(sck_q));
  a_r10_clock_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sck_q);
  a_r11_busy_with_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_q) |-> !busy_q);
endmodule

// File: rtl/qspi_ddr_tx.sv
module qspi_ddr_tx
  import qspi_ddr_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              launch_i,
  input  state_e            state_i,
  input  logic              cnt_lsb_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [NIB_W-1:0]  dq_o,
  output logic [NIB_W-1:0]  dq_oe_o,
  output logic              wr_pop_o
);
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NIB_W-1:0]  lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      addr_q   <= '0;
      lo_q     <= '0;
      dq_o     <= '0;
      dq_oe_o  <= '0;
      wr_pop_o <= 1'b0;
    end else begin
      wr_pop_o <= 1'b0;
      if (start_i) begin
        op_q   <= opcode_i;
        addr_q <= addr_i;
      end
      if (state_i == ST_END) begin
        dq_o    <= '0;
        dq_oe_o <= '0;
      end else if (launch_i) begin
        case (state_i)
          ST_CMD: if (!cnt_lsb_i) begin
            dq_o    <= {{(NIB_W-1){1'b0}}, op_q[OP_W-1]};
            op_q    <= {op_q[OP_W-2:0], 1'b0};
            dq_oe_o <= 4'b0001;
          end
          ST_ADDR: begin
            dq_o    <= addr_q[ADDR_W-1 -: NIB_W];
            addr_q  <= addr_q << NIB_W;
            dq_oe_o <= '1;
          end
          ST_WDATA: begin
            dq_oe_o <= '1;
            if (!cnt_lsb_i) begin
              dq_o     <= wr_data_i[BYTE_W-1 -: NIB_W];
              lo_q     <= wr_data_i[NIB_W-1:0];
              wr_pop_o <= 1'b1;
            end else begin
              dq_o <= lo_q;
            end
          end
          default: begin // latency and read data: bus released
            dq_o    <= '0;
            dq_oe_o <= '0;
          end
        endcase
      end
    end
  end

  a_r3_cmd_single_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && state_i == ST_CMD && !cnt_lsb_i) |=> (dq_oe_o == 4'b0001));
  a_r6_turnaround_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && (state_i == ST_LAT || state_i == ST_RDATA)) |=> (dq_oe_o == '0));
endmodule

// File: rtl/qspi_ddr_rx.sv
module qspi_ddr_rx
  import qspi_ddr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sck_tgl_i,
  input  state_e            state_i,
  input  logic [NIB_W-1:0]  dq_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic             cap_q, half_q;
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q      <= 1'b0;
      half_q     <= 1'b0;
      hi_q       <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      // sample one core cycle after each data edge
      cap_q <= sck_tgl_i && (state_i == ST_RDATA);
      if (start_i) half_q <= 1'b0;
      if (cap_q) begin
        if (!half_q) begin
          hi_q   <= dq_i;
          half_q <= 1'b1;
        end else begin
          rd_data_o  <= {hi_q, dq_i};
          rd_valid_o <= 1'b1;
          half_q     <= 1'b0;
        end
      end
    end
  end

  a_r7_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

// File: rtl/qspi_ddr_ctrl.sv
module qspi_ddr_ctrl
  import qspi_ddr_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int OP_W   = 8,
  parameter int ADDR_W = 24,
  parameter int LAT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              write_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic              busy_o,
  input  logic [7:0]        wr_data_i,
  output logic              wr_pop_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  input  logic [3:0]        dq_i
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int MAX_LL    = (LEN_W > LAT_W) ? LEN_W : LAT_W;
  localparam int OP_BITS   = $clog2(2*OP_W) + 1;
  localparam int CNT_W     = (MAX_LL + 2 > OP_BITS) ? MAX_LL + 2 : OP_BITS;

  state_e state;
  logic   cnt_lsb, start, launch, sck_tgl;

  qspi_ddr_seq #(
    .OP_W(OP_W), .ADDR_NIBS(ADDR_NIBS), .LEN_W(LEN_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni, .req_i, .write_i, .lat_i, .len_i,
    .state_o(state), .cnt_lsb_o(cnt_lsb), .start_o(start), .launch_o(launch),
    .sck_tgl_o(sck_tgl), .cs_n_o, .sck_o, .busy_o
  );

  qspi_ddr_tx #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_tx (
    .clk_i, .rst_ni, .start_i(start), .launch_i(launch), .state_i(state),
    .cnt_lsb_i(cnt_lsb), .opcode_i, .addr_i, .wr_data_i, .dq_o, .dq_oe_o, .wr_pop_o
  );

  qspi_ddr_rx u_rx (
    .clk_i, .rst_ni, .start_i(start), .sck_tgl_i(sck_tgl), .state_i(state),
    .dq_i, .rd_data_o, .rd_valid_o
  );

  // pop tally per transaction, kept apart from the sequencer's own count
  logic [LEN_W:0]   pops_q;
  logic [LEN_W-1:0] len_chk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pops_q    <= '0;
      len_chk_q <= '0;
    end else if (start) begin
      pops_q    <= '0;
      len_chk_q <= len_i;
    end else if (wr_pop_o) begin
      pops_q <= pops_q + 1'b1;
    end
  end

  a_r8_no_over_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pops_q <= {1'b0, len_chk_q});
endmodule

// File: tb/qspi_ddr_ctrl_tb.sv
module qspi_ddr_ctrl_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, write_i = 0;
  logic [7:0] opcode_i = 0;
  logic [23:0] addr_i = 0;
  logic [7:0] len_i = 0;
  logic [3:0] lat_i = 0;
  logic busy_o, wr_pop_o, rd_valid_o, cs_n_o, sck_o;
  logic [7:0] wr_data_i = 0, rd_data_o;
  logic [3:0] dq_o, dq_oe_o, dq_i = 0;

  always #10 clk = ~clk;

  qspi_ddr_ctrl u_dut (
    .clk_i(clk), .rst_ni, .req_i, .write_i, .opcode_i, .addr_i, .len_i, .lat_i,
    .busy_o, .wr_data_i, .wr_pop_o, .rd_data_o, .rd_valid_o,
    .cs_n_o, .sck_o, .dq_o, .dq_oe_o, .dq_i
  );

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct packed {
    logic cs, sck; logic [3:0] oe, dq; logic busy, pop, vld; logic [7:0] byt;
  } ent_t;
  ent_t q[$];

  function automatic logic [7:0] rbyte(logic [23:0] a, int m);
    return a[7:0] ^ 8'(m*29 + 7);
  endfunction
  function automatic logic [7:0] wbyte(logic [7:0] s, int m);
    return s + 8'(m*53);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  // flash-side model: counts clock edges from chip select low
  int fl_edges = 0, m_lat = 0, w_idx = 0;
  logic prev_sck = 0, m_wr = 0;
  logic [23:0] m_addr = 0;
  logic [7:0] w_seed = 0;
  always @(negedge clk) begin
    if (cs_n_o === 1'b1) fl_edges = 0;
    else if (sck_o !== prev_sck) begin
      fl_edges++;
      if (!m_wr && fl_edges > 22 + 2*m_lat) begin
        automatic int d = fl_edges - 23 - 2*m_lat;
        automatic logic [7:0] b = rbyte(m_addr, d/2);
        dq_i = (d % 2 == 0) ? b[7:4] : b[3:0];
      end
    end
    prev_sck = sck_o;
    if (wr_pop_o === 1'b1) begin
      w_idx++;
      wr_data_i = wbyte(w_seed, w_idx);
    end
  end

  function automatic void push(logic cs, logic sck, logic [3:0] oe, logic [3:0] dq,
                               logic busy, logic pop, logic vld, logic [7:0] byt);
    ent_t e;
    e.cs = cs; e.sck = sck; e.oe = oe; e.dq = dq; e.busy = busy;
    e.pop = pop; e.vld = vld; e.byt = byt;
    q.push_back(e);
  endfunction

  // expected cycle-by-cycle waveform from the requirements
  function automatic void build(logic [7:0] op, logic [23:0] a, int len, bit wr, int lat,
                                logic [7:0] seed);
    logic sck = 0, pv = 0, pop;
    logic [3:0] dq = 0, oe = 0;
    logic [7:0] pb = 0;
    int n_edges = 22 + (wr ? 2*len : 2*lat + 2*len);
    push(1, 0, 0, 0, 1, 0, 0, 0);
    push(0, 0, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < n_edges; k++) begin
      pop = 0;
      if (k < 16) begin
        if (k % 2 == 0) begin dq = {3'b000, op[7 - k/2]}; oe = 4'b0001; end
      end else if (k < 22) begin
        dq = a[23 - 4*(k-16) -: 4]; oe = 4'hF;
      end else if (wr) begin
        automatic int d = k - 22;
        automatic logic [7:0] b = wbyte(seed, d/2);
        oe = 4'hF;
        if (d % 2 == 0) begin dq = b[7:4]; pop = 1; end else dq = b[3:0];
      end else begin
        dq = 0; oe = 0;
      end
      push(0, sck, oe, dq, 1, pop, pv, pb);
      pv = 0;
      sck = ~sck;
      push(0, sck, oe, dq, 1, 0, 0, 0);
      if (!wr && k >= 22 + 2*lat && (k - 22 - 2*lat) % 2 == 1) begin
        pv = 1; pb = rbyte(a, (k - 22 - 2*lat)/2);
      end
    end
    push(1, 0, 0, 0, 0, 0, pv, pb);
  endfunction

  task automatic run(logic [7:0] op, logic [23:0] a, int len, bit wr, int lat, bit poke,
                     logic [7:0] seed);
    int idx = 0;
    ent_t e;
    m_wr = wr; m_addr = a; m_lat = lat; w_seed = seed; w_idx = 0;
    wr_data_i = wbyte(seed, 0);
    build(op, a, len, wr, lat, seed);
    req_i = 1; write_i = wr; opcode_i = op; addr_i = a; len_i = 8'(len); lat_i = 4'(lat);
    while (q.size() > 0) begin
      @(negedge clk);
      req_i = poke && (idx == 8);  // R2: request during busy must be ignored
      if (req_i) begin
        opcode_i = ~op; addr_i = ~a; write_i = ~wr; len_i = 8'd200; lat_i = 4'd3;
      end
      e = q.pop_front();
      chk("R2 R9 R11 cs", cs_n_o, e.cs);
      chk("R4 R10 sck", sck_o, e.sck);
      chk("R3 R5 R6 oe", dq_oe_o, e.oe);
      if (e.oe == 4'hF) chk("R5 R8 dq", dq_o, e.dq);
      else if (e.oe == 4'b0001) chk("R3 dq0", dq_o[0], e.dq[0]);
      chk("R2 R11 busy", busy_o, e.busy);
      chk("R8 pop", wr_pop_o, e.pop);
      chk("R7 valid", rd_valid_o, e.vld);
      if (e.vld) chk("R7 R12 rdata", rd_data_o, e.byt);
      idx++;
    end
    req_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 cs", cs_n_o, 1);
    chk("R1 sck", sck_o, 0);
    chk("R1 oe", dq_oe_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 valid", rd_valid_o, 0);
    chk("R1 pop", wr_pop_o, 0);
    run(8'hED, 24'h12A5C3, 3, 0, 8, 0, 8'h00);   // read, typical latency
    run(8'h32, 24'hF0E1D2, 2, 1, 5, 0, 8'h3C);   // back-to-back write, R11 gap
    run(8'h0B, 24'h00FF80, 2, 0, 0, 0, 8'h00);   // R12 zero latency
    run(8'hA5, 24'h5A5A5A, 1, 0, 2, 1, 8'h00);   // R2 poke while busy
    run(8'h06, 24'h800001, 0, 1, 0, 0, 8'h11);   // R9 zero-length write
    run(8'h6B, 24'h3C3C3C, 0, 0, 15, 0, 8'h00);  // zero-length read, max latency
    run(8'h38, 24'hABCDEF, 5, 1, 0, 1, 8'hC7);   // write with poke
    run(8'hEB, 24'h7F0010, 4, 0, 1, 0, 8'h00);   // read, latency 1
    repeat (3) @(negedge clk);
    chk("R10 idle cs", cs_n_o, 1);
    chk("R10 idle sck", sck_o, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule